// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block acts as a small read-only serial EEPROM of 256 bytes that a host drives by writing clock and data line levels one register write at a time. Each write presents a sampled SCL/SDA pair together with a one-cycle strobe. The block compares each pair with the previous one. From that it detects bus start and stop conditions, valid clock edges and illegal data changes.

A transaction begins with a start condition. Eight command bits follow, then an acknowledge slot. Then come eight further bit times. Under a write command those bits form a word address. Under a read command they carry the current data byte out, MSB first. On the seventeenth edge the data register is reloaded from the store at the current address, and the block acknowledges again. A host therefore selects an address with a write command, issues a start again, and fetches the byte with a read command. The host reads the returned line as bit 0 of a word whose upper bits come from a separately supplied host value.

Top module: `eeprom_bitbang_resp`

## Requirements
- R1: With SCL high on both the previous and the current strobed sample, an SDA fall is a start: tick_o becomes 1 and ack_o 0. An SDA rise is a stop: tick_o becomes 0 and ack_o 0. Both release sda_o to 1. Neither condition alters the word address or the data register.
- R2: While tick_o is 0 and ack_o is 0, valid clock edges change nothing: tick_o stays 0 and sda_o keeps its value.
- R3: An SCL rise (previous sample 0, current 1) with an SDA change raises glitch_o for the one cycle after the strobe, and it changes neither tick_o, ack_o nor sda_o.
- R4: A valid edge is an SCL rise with SDA equal to its previous sample. After a start, edges 1 to 8 shift the command in MSB first, with sda_o held at 1. Each valid edge while armed advances tick_o by one. After the 8th edge, ack_o is 1 and sda_o is 0 until the 9th edge.
- R5: Command bit 0 equal to 0 selects write. Edges 10 to 17 then shift the word address in MSB first, with sda_o at 1.
- R6: Command bit 0 equal to 1 selects read. After edges 9 to 16, sda_o presents the data register bits 7 down to 0.
- R7: After the 17th edge, the data register is reloaded from the store at the address now held, and ack_o is 1 with sda_o 0. The 18th edge returns tick_o to 0, clears ack_o and releases sda_o to 1.
- R8: The store is read-only. The byte at address a is (37*a + 11) mod 256. After reset, the data register holds the byte at address 0.
- R9: rd_word_o equals {host_bits_i, sda_o}, so the returned line sits in bit 0.
- R10: After reset: tick_o is 0, ack_o is 0, sda_o is 1 and glitch_o is 0. The previous-sample registers hold SCL=1 and SDA=1.
- R11: Without strobe_i, line input changes have no effect: outputs hold and glitch_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | One-cycle qualifier for a new line sample |
| scl_i | input | 1 | Host-written clock line level |
| sda_i | input | 1 | Host-written data line level |
| host_bits_i | input | BYTE_W-1 (7) | Stored host value returned in the upper bits |
| rd_word_o | output | BYTE_W (8) | Host read word, sda_o in bit 0 |
| sda_o | output | 1 | Data line level driven back by the responder |
| tick_o | output | TICK_W (5) | Transaction bit counter |
| ack_o | output | 1 | Acknowledge slot active |
| glitch_o | output | 1 | Pulse: SDA changed together with an SCL rise |

## Verification
Assertions check several properties on every cycle. A start always arms the counter at 1 and a stop always idles it. Idle edges and glitches leave the transaction registers unchanged. An acknowledge always pulls sda_o low. The line stays released during the command phase, during write address bits and whenever the counter is idle. Nothing moves without a strobe. Only the bench scenarios can show that whole transactions work: that an address written in one transaction selects the byte read back MSB first in the next, that the store returns the formula values at addresses 0, 0x3C and 0xFF, and that a stop in the middle of a command or a repeated start restarts the sequence correctly.

// File: rtl/eeprom_bb_pkg.sv
package eeprom_bb_pkg;

    // Classified line event produced from one strobed sample pair.
    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_STOP,
        EV_BIT,
        EV_GLITCH
    } line_ev_e;

    typedef struct packed {
        line_ev_e kind;
        logic     value;   // SDA level carried by a valid clock edge
    } line_ev_t;

    // What the responder does with its returned data line on this event.
    typedef enum logic [1:0] {
        DRV_KEEP,
        DRV_RELEASE,
        DRV_ACK,
        DRV_DATA
    } drv_sel_e;

    // Fixed store contents: byte at address a = 37*a + 11 (truncated by caller).
    function automatic logic [31:0] rom_word(input logic [31:0] addr);
        return addr * 32'd37 + 32'd11;
    endfunction

endpackage

// File: rtl/eeb_line_watch.sv
module eeb_line_watch
    import eeprom_bb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic prev_scl_q;
    logic prev_sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl_q <= 1'b1;
            prev_sda_q <= 1'b1;
        end else if (strobe_i) begin
            prev_scl_q <= scl_i;
            prev_sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.kind  = EV_NONE;
        ev_o.value = sda_i;
        if (strobe_i) begin
            if (prev_scl_q && scl_i && (prev_sda_q != sda_i)) begin
                ev_o.kind = sda_i ? EV_STOP : EV_START;
            end else if (!prev_scl_q && scl_i) begin
                ev_o.kind = (sda_i == prev_sda_q) ? EV_BIT : EV_GLITCH;
            end
        end
    end

    // R11: the remembered sample only moves on a strobe
    assert_sample_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(prev_scl_q) && $stable(prev_sda_q));

endmodule

// File: rtl/eeb_phase_seq.sv
module eeb_phase_seq
    import eeprom_bb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o,
    output logic              is_read_o,
    output drv_sel_e          drv_o,
    output logic              load_o,
    output logic [BYTE_W-1:0] load_addr_o
);

    localparam logic [TICK_W-1:0] T_ZERO     = '0;
    localparam logic [TICK_W-1:0] T_ONE      = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_CMD_LAST = TICK_W'(BYTE_W);
    localparam logic [TICK_W-1:0] T_ACK1     = TICK_W'(BYTE_W + 1);
    localparam logic [TICK_W-1:0] T_ADR_LAST = TICK_W'(2 * BYTE_W + 1);
    localparam logic [TICK_W-1:0] T_END      = TICK_W'(2 * BYTE_W + 2);

    logic [TICK_W-1:0] tick_q, tick_n;
    logic              ack_q, ack_n;
    logic [BYTE_W-1:0] cmd_q, cmd_n;
    logic [BYTE_W-1:0] addr_q, addr_n;
    logic              armed;

    assign armed = (tick_q != T_ZERO) || ack_q;

    always_comb begin
        tick_n = tick_q;
        ack_n  = ack_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        drv_o  = DRV_KEEP;
        load_o = 1'b0;
        unique case (ev_i.kind)
            EV_START: begin
                tick_n = T_ONE;
                ack_n  = 1'b0;
                cmd_n  = '0;
                drv_o  = DRV_RELEASE;
            end
            EV_STOP: begin
                tick_n = T_ZERO;
                ack_n  = 1'b0;
                cmd_n  = '0;
                drv_o  = DRV_RELEASE;
            end
            EV_BIT: begin
                if (armed) begin
                    if (tick_q <= T_CMD_LAST) begin
                        // command phase
                        cmd_n  = {cmd_q[BYTE_W-2:0], ev_i.value};
                        tick_n = tick_q + T_ONE;
                        if (tick_q == T_CMD_LAST) begin
                            ack_n = 1'b1;
                            drv_o = DRV_ACK;
                        end else begin
                            drv_o = DRV_RELEASE;
                        end
                    end else if (tick_q == T_ACK1) begin
                        // acknowledge slot consumed, first data bit on read
                        ack_n  = 1'b0;
                        tick_n = tick_q + T_ONE;
                        drv_o  = cmd_q[0] ? DRV_DATA : DRV_RELEASE;
                    end else if (tick_q < T_ADR_LAST) begin
                        tick_n = tick_q + T_ONE;
                        if (!cmd_q[0]) begin
                            addr_n = {addr_q[BYTE_W-2:0], ev_i.value};
                        end
                        drv_o = cmd_q[0] ? DRV_DATA : DRV_RELEASE;
                    end else if (tick_q == T_ADR_LAST) begin
                        // last address bit, reload and acknowledge
                        tick_n = tick_q + T_ONE;
                        if (!cmd_q[0]) begin
                            addr_n = {addr_q[BYTE_W-2:0], ev_i.value};
                        end
                        load_o = 1'b1;
                        ack_n  = 1'b1;
                        drv_o  = DRV_ACK;
                    end else begin
                        // final acknowledge slot: back to idle
                        tick_n = T_ZERO;
                        ack_n  = 1'b0;
                        drv_o  = DRV_RELEASE;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= T_ZERO;
            ack_q  <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            tick_q <= tick_n;
            ack_q  <= ack_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
        end
    end

    assign tick_o      = tick_q;
    assign ack_o       = ack_q;
    assign is_read_o   = cmd_q[0];
    assign load_addr_o = addr_n;

    // R1: a start always arms the counter, a stop always idles it
    assert_start_arms_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_i.kind == EV_START) |=> (tick_q == T_ONE) && !ack_q && $stable(addr_q));
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_i.kind == EV_STOP) |=> (tick_q == T_ZERO) && !ack_q && $stable(addr_q));

    // R2: idle edges leave every transaction register alone
    assert_idle_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_i.kind == EV_BIT && tick_q == T_ZERO && !ack_q)
        |=> (tick_q == T_ZERO) && $stable(cmd_q) && $stable(addr_q));

    // R3: a glitch changes no transaction state
    assert_glitch_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_i.kind == EV_GLITCH)
        |=> $stable(tick_q) && $stable(ack_q) && $stable(cmd_q) && $stable(addr_q));

    // R7: the counter never passes the final acknowledge slot
    assert_tick_bound_R7: assert property (@(posedge clk) disable iff (rst)
        tick_q <= T_END);

endmodule

// File: rtl/eeb_byte_store.sv
module eeb_byte_store
    import eeprom_bb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  drv_sel_e          drv_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_addr_i,
    output logic              sda_o
);

    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] rom_val;
    logic [BYTE_W-1:0] rom_zero;
    logic              sda_q;

    assign rom_val  = BYTE_W'(rom_word(32'(load_addr_i)));
    assign rom_zero = BYTE_W'(rom_word(32'd0));

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= rom_zero;
            sda_q  <= 1'b1;
        end else begin
            unique case (drv_i)
                DRV_RELEASE: sda_q <= 1'b1;
                DRV_ACK:     sda_q <= 1'b0;
                DRV_DATA: begin
                    sda_q  <= data_q[BYTE_W-1];
                    data_q <= {data_q[BYTE_W-2:0], 1'b0};
                end
                default: begin
                end
            endcase
            if (load_i) begin
                data_q <= rom_val;
            end
        end
    end

    assign sda_o = sda_q;

    // R6: a read bit presents the byte MSB first and moves it up by one
    assert_shift_msb_first_R6: assert property (@(posedge clk) disable iff (rst)
        (drv_i == DRV_DATA && !load_i)
        |=> (sda_q == $past(data_q[BYTE_W-1])) && (data_q[BYTE_W-1:1] == $past(data_q[BYTE_W-2:0])));

endmodule

// File: rtl/eeprom_bitbang_resp.sv
module eeprom_bitbang_resp
    import eeprom_bb_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int TICK_W = $clog2(2 * BYTE_W + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-2:0] host_bits_i,
    output logic [BYTE_W-1:0] rd_word_o,
    output logic              sda_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o,
    output logic              glitch_o
);

    localparam logic [TICK_W-1:0] T_ZERO     = '0;
    localparam logic [TICK_W-1:0] T_CMD_LAST = TICK_W'(BYTE_W);
    localparam logic [TICK_W-1:0] T_ADR_FST  = TICK_W'(BYTE_W + 2);
    localparam logic [TICK_W-1:0] T_ADR_LAST = TICK_W'(2 * BYTE_W + 1);

    line_ev_t          ev;
    drv_sel_e          drv;
    logic              load;
    logic [BYTE_W-1:0] load_addr;
    logic              is_read;
    logic              glitch_q;

    eeb_line_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev_o     (ev)
    );

    eeb_phase_seq #(
        .BYTE_W (BYTE_W),
        .TICK_W (TICK_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .tick_o      (tick_o),
        .ack_o       (ack_o),
        .is_read_o   (is_read),
        .drv_o       (drv),
        .load_o      (load),
        .load_addr_o (load_addr)
    );

    eeb_byte_store #(
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .drv_i       (drv),
        .load_i      (load),
        .load_addr_i (load_addr),
        .sda_o       (sda_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            glitch_q <= 1'b0;
        end else begin
            glitch_q <= (ev.kind == EV_GLITCH);
        end
    end

    assign glitch_o  = glitch_q;
    assign rd_word_o = {host_bits_i, sda_o};

    // R4: acknowledge always pulls the line low
    assert_ack_low_R4: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !sda_o);

    // R4: command bits never drive the line
    assert_cmd_released_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_o != T_ZERO && tick_o <= T_CMD_LAST) |-> sda_o);

    // R5: write address bits never drive the line
    assert_addr_released_R5: assert property (@(posedge clk) disable iff (rst)
        (!is_read && tick_o >= T_ADR_FST && tick_o <= T_ADR_LAST) |-> sda_o);

    // R7: the line is released whenever the counter is idle
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_o == T_ZERO) |-> sda_o);

    // R11: without a strobe nothing observable moves
    assert_quiet_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(tick_o) && $stable(sda_o) && $stable(ack_o) && !glitch_o);

endmodule

// File: tb/tb_eeprom_bitbang_resp.sv
`timescale 1ns/1ps
module tb_eeprom_bitbang_resp;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] hbits = 7'h52;
    logic [7:0] rd_word;
    logic       sda_o;
    logic [4:0] tick;
    logic       ack;
    logic       glitch;

    always #4 clk = ~clk;   // 125 MHz

    eeprom_bitbang_resp dut (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (strobe),
        .scl_i       (scl),
        .sda_i       (sda),
        .host_bits_i (hbits),
        .rd_word_o   (rd_word),
        .sda_o       (sda_o),
        .tick_o      (tick),
        .ack_o       (ack),
        .glitch_o    (glitch)
    );

    typedef struct {
        logic       sda;
        logic [4:0] tick;
        logic       ack;
        logic       glitch;
        string      req;
    } exp_t;

    exp_t  sb[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R4";

    // reference model state, built from the requirements
    int         m_tick;
    bit         m_ack, m_sda, m_glitch, p_scl, p_sda;
    logic [7:0] m_cmd, m_addr, m_data;

    function automatic logic [7:0] rom_ref(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tick = 0; m_ack = 0; m_sda = 1; m_glitch = 0;
        p_scl = 1; p_sda = 1; m_cmd = 0; m_addr = 0; m_data = rom_ref(0);
    endtask

    task automatic model_step(input bit s_cl, input bit s_da);
        m_glitch = 0;
        if (p_scl && s_cl && (p_sda != s_da)) begin
            m_tick = s_da ? 0 : 1; m_ack = 0; m_cmd = 0; m_sda = 1;
        end else if (!p_scl && s_cl) begin
            if (s_da != p_sda) begin
                m_glitch = 1;
            end else if (m_tick != 0 || m_ack) begin
                if (m_tick <= 8) begin
                    m_cmd = {m_cmd[6:0], s_da};
                    m_tick++;
                    if (m_tick == 9) begin m_ack = 1; m_sda = 0; end
                    else m_sda = 1;
                end else if (m_tick == 9) begin
                    m_ack = 0; m_tick = 10;
                    if (m_cmd[0]) begin m_sda = m_data[7]; m_data = m_data << 1; end
                    else m_sda = 1;
                end else if (m_tick <= 17) begin
                    if (!m_cmd[0]) m_addr = {m_addr[6:0], s_da};
                    if (m_tick == 17) begin
                        m_data = rom_ref(m_addr); m_ack = 1; m_sda = 0;
                    end else if (m_cmd[0]) begin
                        m_sda = m_data[7]; m_data = m_data << 1;
                    end else m_sda = 1;
                    m_tick++;
                end else begin
                    m_tick = 0; m_ack = 0; m_sda = 1;
                end
            end
        end
        p_scl = s_cl; p_sda = s_da;
    endtask

    // driver: one strobed line sample, expected result pushed to the scoreboard
    task automatic step(input bit s_cl, input bit s_da);
        exp_t e;
        @(negedge clk);
        scl = s_cl; sda = s_da; strobe = 1'b1;
        model_step(s_cl, s_da);
        e.sda = m_sda; e.tick = 5'(m_tick); e.ack = m_ack; e.glitch = m_glitch; e.req = cur_req;
        sb.push_back(e);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    // monitor: compares one cycle after the strobed edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(sda_o == e.sda, e.req, "sda_o", sda_o, e.sda);
                check(tick == e.tick, e.req, "tick_o", tick, e.tick);
                check(ack == e.ack, e.req, "ack_o", ack, e.ack);
                check(glitch == e.glitch, e.req, "glitch_o", glitch, e.glitch);
            end
        end
    end

    task automatic send_bit(input bit b);
        step(0, b); step(1, b); step(0, b);
    endtask

    task automatic do_start();
        if (!p_scl) begin step(0, 1); step(1, 1); end
        else if (!p_sda) begin step(0, 0); step(0, 1); step(1, 1); end
        step(1, 0);
    endtask

    task automatic do_stop();
        step(0, 0); step(1, 0); step(1, 1);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic write_addr(input logic [7:0] a);
        cur_req = "R4"; do_start(); send_byte(8'hA0);
        send_bit(1);                               // acknowledge slot, edge 9
        cur_req = "R5"; send_byte(a);              // edges 10..17
        cur_req = "R7"; send_bit(1);               // edge 18
        do_stop();
    endtask

    task automatic read_byte(output logic [7:0] got);
        cur_req = "R4"; do_start(); send_byte(8'hA1);
        cur_req = "R6";
        send_bit(1);                               // edge 9, bit 7 appears
        got[7] = sda_o;
        for (int i = 6; i >= 0; i--) begin
            send_bit(1);
            got[i] = sda_o;
        end
        cur_req = "R7"; send_bit(1); send_bit(1);  // edges 17 and 18
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(tick == 0, "R10", "tick_o", tick, 0);
        check(ack == 0, "R10", "ack_o", ack, 0);
        check(sda_o == 1, "R10", "sda_o", sda_o, 1);
        check(glitch == 0, "R10", "glitch_o", glitch, 0);
        // R9 host word
        check(rd_word == {7'h52, 1'b1}, "R9", "rd_word_o", rd_word, {7'h52, 1'b1});

        // R2 clock edges before any start are ignored
        cur_req = "R2";
        step(0, 1); step(1, 1); step(0, 0); step(1, 0); step(0, 1); step(1, 1);

        // R11 line changes without strobe: would be a start if strobed
        scl = 1'b1; sda = 1'b0;
        repeat (3) @(negedge clk);
        check(tick == 0, "R11", "tick_o", tick, 0);
        check(sda_o == 1, "R11", "sda_o", sda_o, 1);
        check(glitch == 0, "R11", "glitch_o", glitch, 0);
        sda = 1'b1;

        // R8 reset data is the byte at address 0
        read_byte(got);
        check(got == rom_ref(0), "R8", "reset read byte", got, rom_ref(0));

        // R5/R6/R8 random read at 0x3C, read twice
        write_addr(8'h3C);
        read_byte(got);
        check(got == rom_ref(8'h3C), "R6", "read byte 0x3C", got, rom_ref(8'h3C));
        read_byte(got);
        check(got == rom_ref(8'h3C), "R8", "second read 0x3C", got, rom_ref(8'h3C));

        // boundary address
        write_addr(8'hFF);
        read_byte(got);
        check(got == rom_ref(8'hFF), "R8", "read byte 0xFF", got, rom_ref(8'hFF));

        // R9 returned line in bit 0 with a new host value
        hbits = 7'h2B;
        @(negedge clk);
        check(rd_word == {7'h2B, sda_o}, "R9", "rd_word_o", rd_word, {7'h2B, sda_o});

        // R1 stop in the middle of the command, then edges are ignored
        cur_req = "R1";
        do_start(); send_bit(1); send_bit(0); send_bit(1);
        do_stop();
        cur_req = "R2";
        send_bit(0); send_bit(1);

        // R3 glitch mid-command: SDA changes with the SCL rise
        cur_req = "R1"; do_start();
        cur_req = "R3";
        send_bit(1);
        step(0, 0); step(1, 1); step(0, 1);
        cur_req = "R4"; send_bit(0);

        // R1 repeated start: address and data must survive
        cur_req = "R1"; do_start();
        write_addr(8'h81);
        read_byte(got);
        check(got == rom_ref(8'h81), "R1", "read after repeated start", got, rom_ref(8'h81));

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule